// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A six-bit line-control word chooses the number of data bits (five to eight), the length of the stop period, and one of five parity options: none, odd, even, forced one, or forced zero. The line rests at logic 1. Bits are timed by an external enable pulse that arrives at sixteen times the bit rate, so every bit lasts sixteen such pulses.

A producer offers a byte with `in_valid` and hands it over when `in_ready` is high. `in_ready` is high only while the transmitter is idle. An accepted byte is held inside the block. Its frame begins on the first baud tick after the cycle of acceptance. The line-control word is captured at that same tick, so it may change at any other moment without disturbing a frame already under way. `tx_busy` covers the whole span from acceptance to the end of the stop period.

Top module: `uart_char_tx`

## Requirements
- R1: While reset is held and just after its release, `tx_out` is 1, `tx_busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit at 0, then the data bits least significant first, then the optional parity bit, then a stop period at 1. Each start, data and parity bit lasts 16 baud ticks. `tx_out` changes only on a clock edge where `baud_tick` is high, and it is 1 whenever `tx_busy` is 0.
- R3: `line_ctl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Input bits above the chosen length are never sent and do not affect parity.
- R4: With `line_ctl[2]` = 0 the stop period is 16 ticks. With `line_ctl[2]` = 1 it is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R5: With `line_ctl[3]` = 0 no parity bit is sent, whatever the value of `line_ctl[5:4]`.
- R6: `line_ctl[5:3]` = 001 sends a parity bit that makes the count of ones over data and parity odd. The value 011 makes that count even.
- R7: `line_ctl[5:3]` = 101 sends a parity bit fixed at 1. The value 111 sends a parity bit fixed at 0.
- R8: `in_ready` is 1 only when `tx_busy` is 0. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `tx_busy` rises on that edge. The start bit begins on the first later edge with `baud_tick` high, even when a tick coincides with the acceptance. `tx_busy` falls on the tick that ends the stop period.
- R9: `line_ctl` is captured on the tick that begins the start bit. Any later change has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Character to send, LSB sent first |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Transmitter can take a byte (idle) |
| line_ctl | input | 6 | Length, stop and parity selection |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| tx_out | output | 1 | Serial line, idles at 1 |
| tx_busy | output | 1 | Byte held or frame in progress |

## Verification
Two events can land on the same edge: the acceptance of a byte and a baud tick. The start bit must still wait for the next tick, so the block must not begin the frame early. The bench provokes this by running one phase with a tick on every cycle, so that every acceptance meets a tick, and other phases with sparse and uneven tick spacing. A behavioural model builds each frame as a queue of per-tick line levels and checks the exact start cycle, the line level and the busy/ready flags on every clock. A second overlap comes from line-control changes made during a frame; these are judged against the model, which uses only the setting captured at the start tick.

// File: rtl/uart_char_tx.sv
module uart_char_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [5:0] line_ctl,
  input  logic       baud_tick,
  output logic       tx_out,
  output logic       tx_busy
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CW-1:0] BIT_END   = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF3_END = CW'(3 * TICKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] TWO_END   = CW'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    dat;
  logic [5:0]    cfg;
  logic [CW-1:0] stop_end, seg_end;
  logic [7:0]    mask;
  logic          dpar, pbit;
  logic [2:0]    last_idx;

  assign in_ready = (st == S_IDLE);
  assign tx_busy  = (st != S_IDLE);
  assign last_idx = 3'd4 + {1'b0, cfg[1:0]};
  assign mask     = 8'hFF >> (2'd3 - cfg[1:0]);
  assign dpar     = ^(dat & mask);
  assign stop_end = !cfg[2] ? BIT_END : (cfg[1:0] == 2'b00 ? HALF3_END : TWO_END);
  assign seg_end  = (st == S_STOP) ? stop_end : BIT_END;

  always_comb begin
    case (cfg[5:4])
      2'b00:   pbit = ~dpar;
      2'b01:   pbit = dpar;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tx_out <= 1'b1;
      cnt <= '0;
      idx <= '0;
      dat <= '0;
      cfg <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          dat <= in_data;
          st  <= S_PEND;
        end
        S_PEND: if (baud_tick) begin
          cfg    <= line_ctl;
          tx_out <= 1'b0;
          cnt    <= '0;
          st     <= S_START;
        end
        default: if (baud_tick) begin
          if (cnt != seg_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            case (st)
              S_START: begin
                idx    <= '0;
                tx_out <= dat[0];
                st     <= S_DATA;
              end
              S_DATA: begin
                if (idx == last_idx) begin
                  if (cfg[3]) begin
                    tx_out <= pbit;
                    st     <= S_PAR;
                  end else begin
                    tx_out <= 1'b1;
                    st     <= S_STOP;
                  end
                end else begin
                  idx    <= idx + 3'd1;
                  tx_out <= dat[idx + 3'd1];
                end
              end
              S_PAR: begin
                tx_out <= 1'b1;
                st     <= S_STOP;
              end
              default: begin
                tx_out <= 1'b1;
                st     <= S_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

module uart_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic baud_tick,
  input logic tx_out,
  input logic tx_busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> tx_out); // R2
  AST_TX_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tx_out) |-> $past(baud_tick)); // R2
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !tx_busy); // R8
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> tx_busy); // R8
  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> tx_out); // R8
endmodule

bind uart_char_tx uart_char_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .baud_tick(baud_tick), .tx_out(tx_out), .tx_busy(tx_busy)
);

// File: tb/sim_uart_char_tx.sv
module sim_uart_char_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic [5:0] line_ctl = '0;
  logic       baud_tick = 1'b0;
  wire        in_ready, tx_out, tx_busy;

  uart_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .line_ctl(line_ctl), .baud_tick(baud_tick),
    .tx_out(tx_out), .tx_busy(tx_busy)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  int tick_div = 3;
  int tick_cnt = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (tick_cnt + 1 >= tick_div) begin
      tick_cnt <= 0;
      baud_tick <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      baud_tick <= 1'b0;
    end
  end

  bit m_tx = 1'b1, m_pend = 1'b0, m_frame = 1'b0;
  logic [7:0] m_data = '0;
  bit q[$];

  function automatic void push_n(bit v, int n);
    for (int i = 0; i < n; i++) q.push_back(v);
  endfunction

  function automatic void build(logic [5:0] c);
    int n = 5 + int'(c[1:0]);
    int ones = 0;
    bit p = 1'b0;
    push_n(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      push_n(m_data[i], 16);
      if (m_data[i]) ones++;
    end
    if (c[3]) begin
      case (c[5:4])
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      push_n(p, 16);
    end
    push_n(1'b1, !c[2] ? 16 : (n == 5 ? 24 : 32));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 1'b1; m_pend = 1'b0; m_frame = 1'b0; q.delete();
    end else begin
      bit acc;
      acc = in_valid && !m_pend && !m_frame;
      if (baud_tick && m_pend) begin
        build(line_ctl);
        m_pend = 1'b0; m_frame = 1'b1;
        m_tx = q.pop_front();
      end else if (baud_tick && m_frame) begin
        if (q.size() == 0) begin
          m_frame = 1'b0; m_tx = 1'b1;
        end else m_tx = q.pop_front();
      end
      if (acc) begin
        m_pend = 1'b1; m_data = in_data;
      end
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("tx_out", tx_out, m_tx);
      chk("tx_busy", tx_busy, m_pend || m_frame);
      chk("in_ready", in_ready, !(m_pend || m_frame));
    end
  end

  task automatic send(logic [7:0] d, logic [5:0] c, bit scramble, bit wait_idle);
    in_data = d; line_ctl = c; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'($urandom);
    if (scramble) begin
      while (tx_out) @(negedge clk);
      repeat (5) @(negedge clk);
      line_ctl = 6'($urandom);
    end
    if (wait_idle) begin
      while (tx_busy) @(negedge clk);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("tx_out in reset", tx_out, 1'b1);
    chk("tx_busy in reset", tx_busy, 1'b0);
    chk("in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("tx_out after reset", tx_out, 1'b1);
    chk("tx_busy after reset", tx_busy, 1'b0);

    cur_req = "R3";
    for (int l = 0; l < 4; l++) send(8'hE5 ^ 8'(l), {4'b0000, 2'(l)}, 0, 1);

    cur_req = "R4";
    for (int l = 0; l < 4; l++) send(8'h3C, {3'b000, 1'b1, 2'(l)}, 0, 1);

    cur_req = "R5";
    for (int m = 0; m < 4; m++) send(8'h96, {2'(m), 1'b0, 1'b0, 2'b11}, 0, 1);

    cur_req = "R6";
    send(8'h07, 6'b001_0_11, 0, 1);
    send(8'h0F, 6'b001_0_10, 0, 1);
    send(8'h07, 6'b011_0_11, 0, 1);
    send(8'h1F, 6'b011_1_00, 0, 1);

    cur_req = "R7";
    send(8'h00, 6'b101_0_11, 0, 1);
    send(8'hFF, 6'b111_1_01, 0, 1);

    cur_req = "R8";
    tick_div = 1;
    for (int k = 0; k < 4; k++) send(8'($urandom), 6'($urandom), 0, 0);
    while (tx_busy) @(negedge clk);
    tick_div = 7;
    for (int k = 0; k < 3; k++) send(8'($urandom), 6'($urandom), 0, 0);
    while (tx_busy) @(negedge clk);
    tick_div = 2;

    cur_req = "R9";
    for (int k = 0; k < 6; k++) send(8'($urandom), 6'($urandom), 1, 1);

    cur_req = "R2";
    for (int k = 0; k < 20; k++) begin
      tick_div = 1 + int'($urandom % 4);
      send(8'($urandom), 6'($urandom), k[0], k[1]);
    end
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL %s watchdog actual hung expected finished", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule